// File: doc/BRIEF.md
# Fixed-Size Video Frame Conformer

This block is a streaming stage on a valid/ready packet link. Each packet is marked by a start flag on its first word and an end flag on its last word. The first word of a packet is a header, and the low four bits of that header give the packet type. The block rewrites every video packet so that exactly `W*H` samples follow the header. `W` and `H` are fixed when the design is elaborated. Packets of any other type go through word for word.

When an input video packet runs long, the block accepts the surplus samples and drops them until the end flag arrives. When an input video packet ends early, the block stops taking input. It then finishes the output frame by repeating the last pixel it accepted. The block never reads the payload of a non-video packet, so such packets cannot change the frame size.

A single output register sits at the edge of the block. That register holds its word steady while downstream ready is low, so backpressure loses no word and repeats no word.

Top module: `frame_conformer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: When the header type (header bits [3:0]) is not zero, the header and every following word are forwarded in order, unchanged, with the input end flag on the same word.
- R3: When the header type is zero, the header is forwarded with `out_sop` high and `out_eop` low. Exactly `W*H` samples follow it (12 by default), and `out_eop` is high on the last of them only.
- R4: A video packet whose end flag arrives on sample `W*H` is forwarded sample for sample, in order.
- R5: In a video packet longer than `W*H`, the samples after sample `W*H` are consumed and never output. The packet that follows is output normally.
- R6: In a video packet that ends after `k < W*H` samples, the `k` samples are output and then `W*H-k` copies of sample `k`. While those copies are being emitted, `in_ready` is low.
- R7: A video header that carries the end flag itself yields a full frame of the last pixel accepted in any earlier video packet. That pixel is 0 if no video sample has been accepted since reset.
- R8: A word that arrives with no start flag while no packet is open is consumed and produces no output.
- R9: While `out_valid` is high and `out_ready` is low, the output word and its flags stay stable. Under any pattern of `out_ready`, the output sequence is the same as it would be with no backpressure.
- R10: Only header bits [3:0] choose the packet class. A type-0 header with nonzero upper bits is still video, and those upper bits are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Input word |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of an input packet |
| in_eop | input | 1 | Last word of an input packet |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_data | output | DW | Output word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First word of an output packet |
| out_eop | output | 1 | Last word of an output packet |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The bench sends frames that are exact, three samples too long, seven samples short, and empty. A counter that compared against the wrong bound would put the output end flag one sample early or late. Dropping the surplus wrongly would leak input samples into the next packet, and padding with the wrong word would show up as zeros or fresh input in the frame tail. The bench also sends a stray word with no start flag and a type-0 header with its upper bits set. A design that decoded the type field wrongly would reshape a pass-through packet or let a video frame through untouched. The exact and short frames are repeated under pseudo-random backpressure, so an output stage that overwrote its held word would drop a sample or repeat one.

// File: rtl/fconf_pkg.sv
package fconf_pkg;
   localparam int TYPE_W = 4;
   localparam logic [TYPE_W-1:0] TYPE_VIDEO = '0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PASS,
      ST_VIDEO,
      ST_DROP,
      ST_PAD
   } fc_state_e;
endpackage

// File: rtl/fc_count.sv
module fc_count #(
   parameter int W         = 4,
   parameter int H         = 3,
   parameter bit SPLIT_CNT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int N   = W * H;
   localparam int CW  = (N > 1) ? $clog2(N) : 1;
   localparam int CWC = (W > 1) ? $clog2(W) : 1;
   localparam int CWR = (H > 1) ? $clog2(H) : 1;

   generate
      if (SPLIT_CNT) begin : g_split
         localparam logic [CWC-1:0] COL_END = CWC'(W - 1);
         localparam logic [CWR-1:0] ROW_END = CWR'(H - 1);
         logic [CWC-1:0] col;
         logic [CWR-1:0] row;
         logic col_end;
         assign col_end = (col == COL_END);
         assign last    = col_end && (row == ROW_END);
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               col <= '0;
               row <= '0;
            end else if (inc) begin
               if (col_end) begin
                  col <= '0;
                  row <= (row == ROW_END) ? '0 : row + 1'b1;
               end else begin
                  col <= col + 1'b1;
               end
            end
         end
      end else begin : g_flat
         localparam logic [CW-1:0] CNT_END = CW'(N - 1);
         logic [CW-1:0] cnt;
         assign last = (cnt == CNT_END);
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt <= '0;
            else if (inc)      cnt <= last ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
   import fconf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [TYPE_W-1:0] in_type,
   input  logic              load_en,
   input  logic              cnt_last,
   output logic              in_ready,
   output logic              emit,
   output logic              emit_sop,
   output logic              emit_eop,
   output logic              sel_pad,
   output logic              cnt_clr,
   output logic              cnt_inc,
   output logic              pix_we
);
   fc_state_e st, nxt;
   logic fire;

   assign fire = in_valid && in_ready;

   always_comb begin
      nxt      = st;
      in_ready = 1'b0;
      emit     = 1'b0;
      emit_sop = 1'b0;
      emit_eop = 1'b0;
      sel_pad  = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      pix_we   = 1'b0;
      case (st)
         ST_IDLE: begin
            in_ready = load_en;
            if (fire && in_sop) begin
               emit     = 1'b1;
               emit_sop = 1'b1;
               if (in_type == TYPE_VIDEO) begin
                  cnt_clr = 1'b1;
                  nxt     = in_eop ? ST_PAD : ST_VIDEO;
               end else begin
                  emit_eop = in_eop;
                  nxt      = in_eop ? ST_IDLE : ST_PASS;
               end
            end
         end
         ST_PASS: begin
            in_ready = load_en;
            if (fire) begin
               emit     = 1'b1;
               emit_eop = in_eop;
               if (in_eop) nxt = ST_IDLE;
            end
         end
         ST_VIDEO: begin
            in_ready = load_en;
            if (fire) begin
               emit     = 1'b1;
               cnt_inc  = 1'b1;
               pix_we   = 1'b1;
               emit_eop = cnt_last;
               if (cnt_last) nxt = in_eop ? ST_IDLE : ST_DROP;
               else          nxt = in_eop ? ST_PAD  : ST_VIDEO;
            end
         end
         ST_DROP: begin
            in_ready = 1'b1;
            if (in_valid && in_eop) nxt = ST_IDLE;
         end
         ST_PAD: begin
            if (load_en) begin
               emit     = 1'b1;
               sel_pad  = 1'b1;
               cnt_inc  = 1'b1;
               emit_eop = cnt_last;
               if (cnt_last) nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end
endmodule

// File: rtl/fc_oreg.sv
module fc_oreg #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_ready,
   input  logic          emit,
   input  logic [DW-1:0] emit_data,
   input  logic          emit_sop,
   input  logic          emit_eop,
   output logic          load_en,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_sop,
   output logic          out_eop
);
   assign load_en = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else if (load_en) out_valid <= emit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data <= '0;
         out_sop  <= 1'b0;
         out_eop  <= 1'b0;
      end else if (load_en && emit) begin
         out_data <= emit_data;
         out_sop  <= emit_sop;
         out_eop  <= emit_eop;
      end
   end
endmodule

// File: rtl/frame_conformer.sv
module frame_conformer
   import fconf_pkg::*;
#(
   parameter int DW        = 12,
   parameter int W         = 4,
   parameter int H         = 3,
   parameter bit SPLIT_CNT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] in_data,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   output logic          in_ready,
   output logic [DW-1:0] out_data,
   output logic          out_valid,
   output logic          out_sop,
   output logic          out_eop,
   input  logic          out_ready
);
   generate
      if (DW < TYPE_W) begin : g_bad_dw
         $error("frame_conformer: DW must hold the packet type field");
      end
      if (W * H < 2) begin : g_bad_size
         $error("frame_conformer: frame must hold at least two samples");
      end
   endgenerate

   logic          load_en, cnt_last;
   logic          emit, emit_sop, emit_eop, sel_pad;
   logic          cnt_clr, cnt_inc, pix_we;
   logic [DW-1:0] last_pix, emit_data;

   always_ff @(posedge clk) begin
      if (!rst_n)      last_pix <= '0;
      else if (pix_we) last_pix <= in_data;
   end

   assign emit_data = sel_pad ? last_pix : in_data;

   fc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .in_type  (in_data[TYPE_W-1:0]),
      .load_en  (load_en),
      .cnt_last (cnt_last),
      .in_ready (in_ready),
      .emit     (emit),
      .emit_sop (emit_sop),
      .emit_eop (emit_eop),
      .sel_pad  (sel_pad),
      .cnt_clr  (cnt_clr),
      .cnt_inc  (cnt_inc),
      .pix_we   (pix_we)
   );

   fc_count #(.W(W), .H(H), .SPLIT_CNT(SPLIT_CNT)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .last  (cnt_last)
   );

   fc_oreg #(.DW(DW)) u_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_ready (out_ready),
      .emit      (emit),
      .emit_data (emit_data),
      .emit_sop  (emit_sop),
      .emit_eop  (emit_eop),
      .load_en   (load_en),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sop   (out_sop),
      .out_eop   (out_eop)
   );
endmodule

// File: rtl/fconf_chk.sv
module fconf_chk #(
   parameter int DW = 12,
   parameter int W  = 4,
   parameter int H  = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] out_data,
   input logic          out_valid,
   input logic          out_sop,
   input logic          out_eop,
   input logic          out_ready
);
   localparam int N = W * H;

   logic        hs, open, vid;
   int unsigned cnt;

   assign hs = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open <= 1'b0;
         vid  <= 1'b0;
         cnt  <= 0;
      end else if (hs) begin
         if (out_sop) begin
            open <= !out_eop;
            vid  <= (out_data[3:0] == 4'd0);
            cnt  <= 0;
         end else begin
            cnt <= cnt + 1;
            if (out_eop) open <= 1'b0;
         end
      end
   end

   // R9: held word stays put under backpressure
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_sop) && $stable(out_eop));

   // R3: end flag of a video packet exactly on sample N
   a_r3_eop_at_size: assert property (@(posedge clk) disable iff (!rst_n)
      hs && open && vid && !out_sop |-> (out_eop == (cnt == N - 1)));

   // R3: a video header never closes its packet
   a_r3_hdr_open: assert property (@(posedge clk) disable iff (!rst_n)
      hs && out_sop && (out_data[3:0] == 4'd0) |-> !out_eop);

   // R8: between packets only a start word may leave
   a_r8_sop_first: assert property (@(posedge clk) disable iff (!rst_n)
      hs && !open |-> out_sop);
endmodule

bind frame_conformer fconf_chk #(.DW(DW), .W(W), .H(H)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_data  (out_data),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .out_ready (out_ready)
);

// File: tb/sim_frame_conformer.sv
`timescale 1ns/1ps
module sim_frame_conformer;
   localparam int DW = 12;
   localparam int W  = 4;
   localparam int H  = 3;
   localparam int N  = W * H;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic          in_ready;
   logic [DW-1:0] out_data;
   logic          out_valid, out_sop, out_eop;
   logic          out_ready = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;

   logic [DW-1:0] log_d [0:255];
   logic          log_s [0:255];
   logic          log_e [0:255];
   int            log_n = 0;

   logic [DW-1:0] exp_d [0:63];
   logic          exp_s [0:63];
   logic          exp_e [0:63];

   logic   bp_on = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   always #2.5 clk = ~clk;

   frame_conformer #(.DW(DW), .W(W), .H(H)) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_ready(out_ready)
   );

   // output monitor, mid-cycle
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && log_n < 256) begin
         log_d[log_n] = out_data;
         log_s[log_n] = out_sop;
         log_e[log_n] = out_eop;
         log_n = log_n + 1;
      end
      if (bp_on) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = lfsr[0] | lfsr[3];
      end else begin
         out_ready = 1'b1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [DW-1:0] d, input logic s, input logic e);
      in_data  = d;
      in_sop   = s;
      in_eop   = e;
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
   endtask

   // header then n samples base+i, end flag on last word
   task automatic send(input logic [DW-1:0] hdr, input logic [DW-1:0] base,
                       input int n);
      put(hdr, 1'b1, n == 0);
      for (int i = 0; i < n; i++) put(base + DW'(i), 1'b0, i == n - 1);
   endtask

   task automatic set_exp(input int i, input logic [DW-1:0] d, input logic s,
                          input logic e);
      exp_d[i] = d;
      exp_s[i] = s;
      exp_e[i] = e;
   endtask

   task automatic expect_video(input logic [DW-1:0] hdr, input logic [DW-1:0] base,
                               input int k);
      set_exp(0, hdr, 1'b1, 1'b0);
      for (int i = 0; i < N; i++)
         set_exp(i + 1, (i < k) ? base + DW'(i) : base + DW'(k - 1), 1'b0, i == N - 1);
   endtask

   task automatic compare(input int base, input int cnt, input string tag);
      wait (log_n >= base + cnt);
      repeat (4) @(negedge clk);
      check(log_n == base + cnt, {tag, " word count"}, log_n - base, cnt);
      for (int i = 0; i < cnt; i++)
         check(log_d[base+i] == exp_d[i] && log_s[base+i] == exp_s[i]
               && log_e[base+i] == exp_e[i], tag,
               {log_s[base+i], log_e[base+i], 2'b0, 16'(log_d[base+i])},
               {exp_s[i], exp_e[i], 2'b0, 16'(exp_d[i])});
   endtask

   task automatic t_reset;
      #1;
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
   endtask

   task automatic t_exact;
      int b = log_n;
      send(12'hAB0, 12'h100, N);
      expect_video(12'hAB0, 12'h100, N);
      compare(b, N + 1, "R4 R10 exact frame, type 0 with upper bits");
   endtask

   task automatic t_pass;
      int b = log_n;
      send(12'h015, 12'h7F0, 3);
      set_exp(0, 12'h015, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) set_exp(i + 1, 12'h7F0 + DW'(i), 1'b0, i == 2);
      compare(b, 4, "R2 R10 non-video passthrough");
   endtask

   task automatic t_long;
      int b = log_n;
      send(12'h000, 12'h180, N + 3);
      send(12'h003, 12'h000, 0);
      expect_video(12'h000, 12'h180, N);
      set_exp(N + 1, 12'h003, 1'b1, 1'b1);
      compare(b, N + 2, "R5 surplus dropped");
   endtask

   task automatic t_short;
      int b = log_n;
      send(12'h000, 12'h200, 5);
      #1;
      check(in_ready == 1'b0, "R6 in_ready low while padding", in_ready, 0);
      expect_video(12'h000, 12'h200, 5);
      compare(b, N + 1, "R6 short frame padded");
   endtask

   task automatic t_empty;
      int b = log_n;
      send(12'h000, 12'h000, 0);
      set_exp(0, 12'h000, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) set_exp(i + 1, 12'h204, 1'b0, i == N - 1);
      compare(b, N + 1, "R7 empty frame");
   endtask

   task automatic t_stray;
      int b = log_n;
      put(12'h777, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      check(log_n == b, "R8 stray word output", log_n - b, 0);
      send(12'h009, 12'h050, 1);
      set_exp(0, 12'h009, 1'b1, 1'b0);
      set_exp(1, 12'h050, 1'b0, 1'b1);
      compare(b, 2, "R8 packet after stray word");
   endtask

   task automatic t_bp;
      int b;
      bp_on = 1'b1;
      b = log_n;
      send(12'h0C0, 12'h300, N);
      expect_video(12'h0C0, 12'h300, N);
      compare(b, N + 1, "R9 exact frame under backpressure");
      b = log_n;
      send(12'h000, 12'h400, 3);
      expect_video(12'h000, 12'h400, 3);
      compare(b, N + 1, "R9 short frame under backpressure");
      bp_on = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_exact();
      t_pass();
      t_long();
      t_short();
      t_empty();
      t_stray();
      t_bp();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", log_n, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule